// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block gathers interrupt requests from ten vector groups and hands the processor a single winning vector address together with a request line. Each group has an enable bit and a level-select bit. The select bit raises the group above the low level. The two lowest-numbered groups rise to the topmost level. All other groups rise only to the middle level.

Arbitration picks the highest level present. Among requests at that level, it picks the lowest vector address. The controller keeps one in-service flag per level. An acknowledge from the processor sets the flag of the vector being presented. A return strobe clears the highest flag that is set. A new request is presented only when its level is strictly above the highest level in service, so nesting goes at most three deep.

Requests are level sensitive: a request stays pending until its source drops it. Pending requests are weighed again after every return.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `int_req` is 0, `int_vec` is 0x03 and no level is in service.
- R2: A request whose `vec_en` bit is 0 takes no part in arbitration. While `glb_en` is 0, `int_req` stays 0, and `int_vec` still follows the winner.
- R3: Vector n is presented with address 0x03 + 8·n, for n from 0 to 9. When no request is eligible, `int_vec` shows 0x03.
- R4: Level encoding is: low = 1, middle = 2, top = 3. The level of vector n is low when `lvl_sel[n]` is 0. When `lvl_sel[n]` is 1, vectors 0 and 1 are at the top level and vectors 2 to 9 are at the middle level.
- R5: When several enabled vectors request at once, the one with the highest level is presented.
- R6: Among requesting vectors of equal level, the lowest vector number is presented.
- R7: While a level is in service, requests at that level or below keep `int_req` at 0. A request at a strictly higher level is presented.
- R8: An `ack` while `int_req` is 1 marks the presented level as in service and forces `int_req` to 0 on the next cycle. An `ack` while `int_req` is 0 has no effect.
- R9: `reti` clears the highest in-service level. A request that is still pending is presented again two cycles after the `reti` cycle.
- R10: `int_req` and `int_vec` are registered. A change at the inputs shows at the outputs after the next rising clock edge, and not before.
- R11: Up to three levels can be in service at once: low, then middle, then top. Successive `reti` strobes unwind them from top to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 10 | Level request per vector group |
| vec_en | input | 10 | Per-vector enable |
| lvl_sel | input | 10 | Per-vector raise to the elevated level |
| glb_en | input | 1 | Global enable for the request output |
| ack | input | 1 | Processor acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| int_req | output | 1 | Request to the processor |
| int_vec | output | 8 | Address of the presented vector |

## Verification
The bench builds the controller with its default parameters: ten vectors, two top-capable vectors, base 0x03, stride 8 and an 8-bit address. With these values the split between top-capable and middle-only vectors is reachable, along with both end addresses 0x03 and 0x4B. The table walk covers level and index ties with no level in service. Directed sequences then build a full three-deep nest and unwind it, checking that equal-level requests stay held until the low level returns.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_MID  = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int   NUM_LVL  = 3;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_vector_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int TOP_VECS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_VEC-1:0]       irq_in,
  input  logic [NUM_VEC-1:0]       vec_en,
  input  logic [NUM_VEC-1:0]       lvl_sel,
  output lvl_t [NUM_VEC-1:0]       lvl
);
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    localparam lvl_t RAISED = (i < TOP_VECS) ? LVL_TOP : LVL_MID;
    always_comb begin
      if (!(irq_in[i] && vec_en[i])) lvl[i] = LVL_NONE;
      else if (lvl_sel[i])           lvl[i] = RAISED;
      else                           lvl[i] = LVL_LOW;
    end
    if (i < TOP_VECS) begin : g_top
      // R4: a top-capable vector never lands on the middle level
      assert_top_capable_R4: assert property (@(posedge clk) disable iff (rst)
        lvl[i] != LVL_MID);
    end else begin : g_mid
      // R4: other vectors never reach the top level
      assert_mid_only_R4: assert property (@(posedge clk) disable iff (rst)
        lvl[i] != LVL_TOP);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vector_pkg::*;
#(
  parameter int NUM_VEC = 10,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lvl_t [NUM_VEC-1:0]   lvl,
  output logic [IDX_W-1:0]     win_idx,
  output lvl_t                 win_lvl
);
  always_comb begin
    win_lvl = LVL_NONE;
    win_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (lvl[i] != LVL_NONE && lvl[i] >= win_lvl) begin
        win_lvl = lvl[i];
        win_idx = IDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_chk
    assert_winner_highest_R5: assert property (@(posedge clk) disable iff (rst)
      lvl[i] <= win_lvl);
    assert_lowest_index_R6: assert property (@(posedge clk) disable iff (rst)
      (IDX_W'(i) < win_idx) |-> (lvl[i] != win_lvl));
  end
endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
  import irq_vector_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cur_lvl
);
  logic [NUM_LVL-1:0] busy_q;
  logic [NUM_LVL-1:0] top_bit;
  logic [NUM_LVL-1:0] push_bit;

  always_comb begin
    top_bit = '0;
    cur_lvl = LVL_NONE;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (busy_q[k]) begin
        top_bit = '0;
        top_bit[k] = 1'b1;
        cur_lvl = lvl_t'(k + 1);
      end
    end
    push_bit = '0;
    if (push && push_lvl != LVL_NONE) push_bit[push_lvl - 2'd1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= (busy_q & ~(pop ? top_bit : '0)) | push_bit;
  end

  // R9: a return with something in service drops exactly one level
  assert_pop_one_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && busy_q != '0) |=> ($countones(busy_q) == $past($countones(busy_q)) - 1));
  // R7: a level enters service only above the current one
  assert_push_above_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_lvl > cur_lvl));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int NUM_VEC    = 10,
  parameter int TOP_VECS   = 2,
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] irq_in,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] lvl_sel,
  input  logic               glb_en,
  input  logic               ack,
  input  logic               reti,
  output logic               int_req,
  output logic [ADDR_W-1:0]  int_vec
);
  localparam int IDX_W = $clog2(NUM_VEC);

  lvl_t [NUM_VEC-1:0] lvl;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  lvl_t               win_lvl_q;
  logic               req_q;
  logic [ADDR_W-1:0]  vec_q;
  logic               ack_take;

  irq_level_map #(.NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS)) u_map (
    .clk(clk), .rst(rst), .irq_in(irq_in), .vec_en(vec_en),
    .lvl_sel(lvl_sel), .lvl(lvl));

  irq_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk(clk), .rst(rst), .lvl(lvl), .win_idx(win_idx), .win_lvl(win_lvl));

  assign ack_take = ack && req_q;

  irq_service_stack u_stack (
    .clk(clk), .rst(rst), .push(ack_take), .push_lvl(win_lvl_q),
    .pop(reti), .cur_lvl(cur_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      vec_q     <= ADDR_W'(VEC_BASE);
      win_lvl_q <= LVL_NONE;
    end else begin
      req_q     <= ack_take ? 1'b0 : (glb_en && (win_lvl > cur_lvl));
      vec_q     <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
      win_lvl_q <= win_lvl;
    end
  end

  assign int_req = req_q;
  assign int_vec = vec_q;

  // R8: an accepted acknowledge withdraws the request on the next cycle
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> !req_q);
  // R7: a presented request is always above the level in service
  assert_nest_strict_R7: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (win_lvl_q > cur_lvl));
  // R2: no request is raised unless the global enable was set
  assert_global_gate_R2: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(glb_en));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] irq_in = '0, vec_en = '0, lvl_sel = '0;
  logic       glb_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic       int_req;
  logic [7:0] int_vec;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .vec_en(vec_en), .lvl_sel(lvl_sel),
    .glb_en(glb_en), .ack(ack), .reti(reti), .int_req(int_req), .int_vec(int_vec));

  // {irq_in, vec_en, lvl_sel, glb_en, expected int_req, expected int_vec}
  localparam int NT = 13;
  localparam logic [39:0] TBL [NT] = '{
    {10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h03},  // R3 idle address
    {10'h020, 10'h3FF, 10'h000, 1'b1, 1'b1, 8'h2B},  // R3
    {10'h200, 10'h3FF, 10'h000, 1'b1, 1'b1, 8'h4B},  // R3
    {10'h220, 10'h3FF, 10'h000, 1'b1, 1'b1, 8'h2B},  // R6
    {10'h084, 10'h3FF, 10'h080, 1'b1, 1'b1, 8'h3B},  // R5
    {10'h081, 10'h3FF, 10'h080, 1'b1, 1'b1, 8'h3B},  // R5
    {10'h082, 10'h3FF, 10'h082, 1'b1, 1'b1, 8'h0B},  // R4
    {10'h003, 10'h3FF, 10'h003, 1'b1, 1'b1, 8'h03},  // R6
    {10'h020, 10'h3DF, 10'h000, 1'b1, 1'b0, 8'h03},  // R2
    {10'h060, 10'h3DF, 10'h000, 1'b1, 1'b1, 8'h33},  // R2
    {10'h008, 10'h3FF, 10'h000, 1'b0, 1'b0, 8'h1B},  // R2
    {10'h110, 10'h3FF, 10'h110, 1'b1, 1'b1, 8'h23},  // R6
    {10'h204, 10'h3FF, 10'h200, 1'b1, 1'b1, 8'h4B}   // R5
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    irq_in = 10'h004; vec_en = 10'h3FF; glb_en = 1'b1;
    step(); step();
    chk("R1 req in reset", {7'd0, int_req}, 8'h00);
    chk("R1 vec in reset", int_vec, 8'h03);
    rst = 1'b0;
    irq_in = '0;
    step();
    chk("R1 req after reset", {7'd0, int_req}, 8'h00);

    for (int t = 0; t < NT; t++) begin
      irq_in  = TBL[t][39:30];
      vec_en  = TBL[t][29:20];
      lvl_sel = TBL[t][19:10];
      glb_en  = TBL[t][9];
      step();
      chk($sformatf("R2-R6 table %0d req", t), {7'd0, int_req}, {7'd0, TBL[t][8]});
      chk($sformatf("R3 table %0d vec", t), int_vec, TBL[t][7:0]);
    end

    // R8: acknowledge while no request is shown is ignored
    irq_in = 10'h004; vec_en = 10'h3FF; lvl_sel = '0; glb_en = 1'b0;
    step();
    chk("R8 gated req", {7'd0, int_req}, 8'h00);
    pulse_ack();
    glb_en = 1'b1;
    step();
    chk("R8 ignored ack req", {7'd0, int_req}, 8'h01);
    chk("R8 ignored ack vec", int_vec, 8'h13);

    // R8 accepted ack; R7 equal level held
    pulse_ack();
    chk("R8 drop after ack", {7'd0, int_req}, 8'h00);
    step();
    chk("R7 same vector held", {7'd0, int_req}, 8'h00);
    irq_in = 10'h00C;
    step();
    chk("R7 equal low held", {7'd0, int_req}, 8'h00);
    irq_in = 10'h01C; lvl_sel = 10'h010;
    step();
    chk("R7 higher req", {7'd0, int_req}, 8'h01);
    chk("R7 higher vec", int_vec, 8'h23);
    pulse_ack();
    chk("R8 drop mid", {7'd0, int_req}, 8'h00);
    irq_in = 10'h01D; lvl_sel = 10'h011;
    step();
    chk("R11 top req", {7'd0, int_req}, 8'h01);
    chk("R11 top vec", int_vec, 8'h03);
    pulse_ack();
    step();
    chk("R11 three deep", {7'd0, int_req}, 8'h00);

    // unwind
    irq_in = 10'h01C;
    pulse_reti(); step();
    chk("R11 mid still busy", {7'd0, int_req}, 8'h00);
    irq_in = 10'h00C;
    pulse_reti(); step();
    chk("R11 low still busy", {7'd0, int_req}, 8'h00);
    pulse_reti(); step();
    chk("R9 re-presented req", {7'd0, int_req}, 8'h01);
    chk("R9 re-presented vec", int_vec, 8'h13);

    // R10: no change before the edge
    irq_in = '0;
    #1;
    chk("R10 before edge", {7'd0, int_req}, 8'h01);
    step();
    chk("R10 after edge", {7'd0, int_req}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule